// File: doc/BRIEF.md
# Selectable-Source Divided Clock Output

This block produces one divided clock-out signal from one of three candidate clocks: a crystal clock, the system clock and a high-speed RC oscillator. The candidates arrive as level signals that the fast block clock samples. The block counts rising edges of the chosen source with a counter that runs on a clock enable, so all of its logic lives in one clock domain. A 4-bit frequency code N sets the division ratio to 2^(N+1). A bypass bit sends the chosen source straight through. Two enables, one local to the divider and one from the peripheral clock gating, must both be set before any output appears.

The output is registered. A gate output tells downstream logic when the divided clock is valid. A new value of N is loaded only when the counter wraps, so a running output never produces a short pulse. Switching between sources is not made glitch-free.

Top module: `fdiv_clkout`

## Requirements
- R1: After reset, `clk_out` and `clk_out_en` are both 0.
- R2: While `div_enable` or `periph_clk_en` is 0, `clk_out` and `clk_out_en` are 0 from the next cycle on. The edge counter is cleared, so a fresh enable starts counting from zero.
- R3: With both enables set and `bypass` 0, `clk_out` is a 50% duty clock. Its period is 2^(N+1) rising edges of the selected source, and it is low for the first 2^N edges after a wrap or a clear.
- R4: With both enables set and `bypass` 1, `clk_out` equals the selected source level one cycle earlier, whatever N is.
- R5: The `src_sel` encoding is 2'b00 crystal (`src_xtal`), 2'b10 system clock (`src_sys`) and 2'b11 RC oscillator (`src_rc`).
- R6: `src_sel` 2'b01 is reserved and selects no source. In divide mode the output holds its level. In bypass mode the output is 0.
- R7: A change of `freq_sel` while the divider runs takes effect only when the counter wraps. It is also loaded while the divider is disabled or in bypass.
- R8: `clk_out_en` is 1 in the cycle after one in which both `div_enable` and `periph_clk_en` are 1.
- R9: An output level changes one clock after the sampled source edge that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples every source level |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_xtal | input | 1 | Crystal clock level |
| src_sys | input | 1 | System clock level |
| src_rc | input | 1 | High-speed RC oscillator level |
| src_sel | input | 2 | Source select code (see R5, R6) |
| freq_sel | input | 4 | Frequency code N, ratio 2^(N+1) |
| div_enable | input | 1 | Divider enable |
| bypass | input | 1 | 1: pass the selected source through undivided |
| periph_clk_en | input | 1 | Peripheral clock enable for the divider output |
| clk_out | output | 1 | Divided clock |
| clk_out_en | output | 1 | Gate: 1 while the divided clock is valid |

## Verification
The assertions assume that each source level changes at most once per block clock. They also assume the levels are already synchronous to `clk`, so one rising edge shows up as exactly one low-to-high step between two samples. The stimulus generates every source as a square wave whose half period is several block clocks, and drives it on the falling edge. Control fields change only between rising edges. The stimulus covers every select code, both enables, bypass, and a mid-run change of N.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int unsigned NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'b00,
        SRC_RSVD = 2'b01,
        SRC_SYS  = 2'b10,
        SRC_RC   = 2'b11
    } src_sel_e;

    // Level vector order: [0] crystal, [1] system clock, [2] RC oscillator
    function automatic logic pick_level(input logic [1:0] sel,
                                        input logic [NUM_SRC-1:0] lv);
        logic res;
        case (sel)
            SRC_XTAL: res = lv[0];
            SRC_SYS:  res = lv[1];
            SRC_RC:   res = lv[2];
            default:  res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/fdiv_src_pick.sv
module fdiv_src_pick
    import fdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [1:0]         src_sel,
    output logic               sel_lvl,
    output logic               sel_rise
);

    typedef struct packed {
        logic [NUM_SRC-1:0] lvl;
    } pick_st_t;

    pick_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = src_lvl;
        sel_lvl  = pick_level(src_sel, src_lvl);
        sel_rise = sel_lvl & ~pick_level(src_sel, st_q.lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter #(
    parameter  int CNT_W = 16,
    localparam int SEL_W = $clog2(CNT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic             tick,
    input  logic [SEL_W-1:0] freq_sel,
    output logic             tap_d
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] nact;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] span;
    logic             terminal;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < CNT_W; i++) begin
            span[i] = (i <= int'(st_q.nact));
        end
        terminal = &(st_q.cnt | ~span);
        if (!run || clear) begin
            st_d.cnt  = '0;
            st_d.nact = freq_sel;
        end else if (tick) begin
            if (terminal) begin
                st_d.cnt  = '0;
                st_d.nact = freq_sel;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        tap_d = st_d.cnt[st_d.nact];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/fdiv_clkout.sv
module fdiv_clkout
    import fdiv_pkg::*;
#(
    parameter  int CNT_W = 16,
    localparam int SEL_W = $clog2(CNT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_xtal,
    input  logic             src_sys,
    input  logic             src_rc,
    input  logic [1:0]       src_sel,
    input  logic [SEL_W-1:0] freq_sel,
    input  logic             div_enable,
    input  logic             bypass,
    input  logic             periph_clk_en,
    output logic             clk_out,
    output logic             clk_out_en
);

    typedef struct packed {
        logic out;
        logic gate;
    } out_st_t;

    out_st_t out_d, out_q;
    logic    run;
    logic    sel_lvl;
    logic    sel_rise;
    logic    tap_d;

    assign run = div_enable & periph_clk_en;

    fdiv_src_pick u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_lvl  ({src_rc, src_sys, src_xtal}),
        .src_sel  (src_sel),
        .sel_lvl  (sel_lvl),
        .sel_rise (sel_rise)
    );

    fdiv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .clear    (bypass),
        .tick     (sel_rise),
        .freq_sel (freq_sel),
        .tap_d    (tap_d)
    );

    always_comb begin
        out_d      = out_q;
        out_d.gate = run;
        if (!run)        out_d.out = 1'b0;
        else if (bypass) out_d.out = sel_lvl;
        else             out_d.out = tap_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign clk_out    = out_q.out;
    assign clk_out_en = out_q.gate;

endmodule

// File: rtl/fdiv_clkout_chk.sv
module fdiv_clkout_chk
    import fdiv_pkg::*;
#(
    parameter  int CNT_W = 16,
    localparam int SEL_W = $clog2(CNT_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             src_xtal,
    input logic             src_sys,
    input logic             src_rc,
    input logic [1:0]       src_sel,
    input logic [SEL_W-1:0] freq_sel,
    input logic             div_enable,
    input logic             bypass,
    input logic             periph_clk_en,
    input logic             clk_out,
    input logic             clk_out_en
);

    logic chk_lvl;
    logic div_mode_q;

    assign chk_lvl = pick_level(src_sel, {src_rc, src_sys, src_xtal});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_mode_q <= 1'b0;
        else        div_mode_q <= div_enable && periph_clk_en && !bypass;
    end

    assert_gate_low_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_out_en |-> !clk_out);

    assert_disabled_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_enable || !periph_clk_en) |=> (!clk_out && !clk_out_en));

    assert_gate_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_enable && periph_clk_en) |=> clk_out_en);

    assert_bypass_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_enable && periph_clk_en && bypass) |=> (clk_out == $past(chk_lvl)));

    assert_reserved_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_mode_q && div_enable && periph_clk_en && !bypass && src_sel == SRC_RSVD)
        |=> $stable(clk_out));

endmodule

bind fdiv_clkout fdiv_clkout_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/fdiv_clkout_tb.sv
`timescale 1ns/1ps
module fdiv_clkout_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_xtal = 1'b0, src_sys = 1'b0, src_rc = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic [3:0] freq_sel = 4'd0;
    logic       div_enable = 1'b0, bypass = 1'b0, periph_clk_en = 1'b0;
    logic       clk_out, clk_out_en;

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R1";
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fdiv_clkout u_dut (
        .clk(clk), .rst_n(rst_n), .src_xtal(src_xtal), .src_sys(src_sys),
        .src_rc(src_rc), .src_sel(src_sel), .freq_sel(freq_sel),
        .div_enable(div_enable), .bypass(bypass), .periph_clk_en(periph_clk_en),
        .clk_out(clk_out), .clk_out_en(clk_out_en)
    );

    // source square waves: half periods 3, 2 and 5 block clocks
    int ph_x = 0, ph_s = 0, ph_r = 0;
    always @(negedge clk) begin
        ph_x = ph_x + 1; if (ph_x == 3) begin ph_x = 0; src_xtal = ~src_xtal; end
        ph_s = ph_s + 1; if (ph_s == 2) begin ph_s = 0; src_sys  = ~src_sys;  end
        ph_r = ph_r + 1; if (ph_r == 5) begin ph_r = 0; src_rc   = ~src_rc;   end
    end

    // behavioural reference model
    function automatic bit lvl_of(input logic [1:0] s, input bit [2:0] v);
        if (s == 2'b00) return v[0];
        if (s == 2'b10) return v[1];
        if (s == 2'b11) return v[2];
        return 1'b0;
    endfunction

    int m_cnt = 0, m_nact = 0;
    bit m_out = 0, m_gate = 0;
    bit [2:0] m_prev = 0;

    always @(posedge clk) begin
        bit run, lv, plv;
        if (!rst_n) begin
            m_cnt = 0; m_nact = 0; m_out = 0; m_gate = 0; m_prev = 0;
        end else begin
            run = div_enable && periph_clk_en;
            lv  = lvl_of(src_sel, {src_rc, src_sys, src_xtal});
            plv = lvl_of(src_sel, m_prev);
            if (!run) begin
                m_cnt = 0; m_nact = int'(freq_sel); m_out = 0;
            end else if (bypass) begin
                m_cnt = 0; m_nact = int'(freq_sel); m_out = lv;
            end else begin
                if (lv && !plv) begin
                    if (m_cnt == (1 << (m_nact + 1)) - 1) begin
                        m_cnt = 0; m_nact = int'(freq_sel);
                    end else m_cnt = m_cnt + 1;
                end
                m_out = ((m_cnt >> m_nact) & 1) != 0;
            end
            m_gate = run;
            m_prev = {src_rc, src_sys, src_xtal};
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model (R9 timing: one clock after the sampled edge)
    always @(negedge clk) begin
        if (chk_on && !done) begin
            check(cur_req, clk_out, m_out, "clk_out vs model (R9)");
            check("R8", clk_out_en, m_gate, "clk_out_en vs model");
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int t0, t1;
        logic held;
        wait_clks(5);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", clk_out, 1'b0, "clk_out after reset");
        check("R1", clk_out_en, 1'b0, "clk_out_en after reset");
        chk_on = 1'b1;

        // R3 / R5: system clock, N=0 then N=1
        cur_req = "R3"; src_sel = 2'b10; freq_sel = 4'd0;
        div_enable = 1'b1; periph_clk_en = 1'b1;
        wait_clks(100);
        freq_sel = 4'd1; wait_clks(100);
        // R3: period of N=1 on system clock (4 clocks per edge) is 16 clocks
        @(posedge clk_out); @(negedge clk); t0 = $time;
        @(posedge clk_out); @(negedge clk); t1 = $time;
        n_checks++;
        if ((t1 - t0) != 16 * 4) begin
            n_fail++;
            $display("FAIL R3 period actual=%0d expected=%0d", (t1 - t0) / 4, 16);
        end

        // R7: change of N mid-run, applied at wrap
        cur_req = "R7"; freq_sel = 4'd3; wait_clks(7); freq_sel = 4'd2; wait_clks(300);

        // R5: crystal and RC sources
        cur_req = "R5"; src_sel = 2'b00; freq_sel = 4'd1; wait_clks(200);
        src_sel = 2'b11; freq_sel = 4'd2; wait_clks(300);

        // R2: peripheral enable off, then divider enable off
        cur_req = "R2"; periph_clk_en = 1'b0; wait_clks(3);
        check("R2", clk_out, 1'b0, "clk_out with periph off");
        check("R2", clk_out_en, 1'b0, "gate with periph off");
        wait_clks(40); periph_clk_en = 1'b1; cur_req = "R3"; wait_clks(150);
        cur_req = "R2"; div_enable = 1'b0; wait_clks(40); div_enable = 1'b1;
        cur_req = "R3"; freq_sel = 4'd5; src_sel = 2'b10; wait_clks(700);

        // R4: bypass on system and RC sources
        cur_req = "R4"; bypass = 1'b1; freq_sel = 4'd9; wait_clks(60);
        src_sel = 2'b11; wait_clks(60);

        // R6: reserved code in bypass, then in divide mode
        cur_req = "R6"; src_sel = 2'b01; wait_clks(30);
        check("R6", clk_out, 1'b0, "bypass with reserved source");
        bypass = 1'b0; src_sel = 2'b10; freq_sel = 4'd1; wait_clks(22);
        src_sel = 2'b01; wait_clks(2); held = clk_out; wait_clks(40);
        check("R6", clk_out, held, "divide mode with reserved source holds");
        src_sel = 2'b00; cur_req = "R5"; wait_clks(100);

        finish_run();
    end

endmodule